// File: doc/BRIEF.md
# Byte-Wide SPI Master with Flag Handshake

This block is a memory-mapped SPI master that moves one byte per transfer. Software writes a control register to choose the bit rate, the clock polarity and the clock phase, and then writes a byte to the data address. The block shifts that byte out on `mosi`, most significant bit first. At the same time it collects eight bits from `miso`. When the eighth bit is complete, the received byte is placed in a read buffer and a completion flag is raised. That flag can drive an interrupt line.

The completion flag is cleared by a two-step handshake. First, software reads the status register while the flag is set, which arms the clear. Then software makes any access to the data address, read or write, and that access clears the flag. Until the status read has happened, writes to the data address are dropped, so a new byte cannot overwrite a pending result by accident.

The select input `ss_n` guards master mode. If `ss_n` goes low while the block is an enabled master, the block leaves master mode, reports a mode fault and abandons the transfer it was running. `ss_n` is sampled without synchronisation, so it must arrive already synchronous to `clk`.

Top module: `spi_master_ctrl`

## Requirements
- R1: After reset, every register address reads 0x00, and `sck` and `irq` are low. The register map is as follows.
  - Address 0 is control: bit0 enable, bit1 master, bit2 clock polarity, bit3 clock phase, bits5:4 rate code, bit6 interrupt enable. It reads back with bit7 = 0.
  - Address 1 is status: bit7 completion flag, bit6 mode fault, all other bits 0.
  - Address 2 is data: a write sends a byte and a read returns the receive buffer.
  - `reg_rdata` is combinational from `reg_addr`. It changes no state unless `reg_rd` is high.
- R2: The rate codes 00, 01, 10 and 11 give SCK periods of 2, 4, 16 and 32 clocks. H is the half period: 1, 2, 8 and 16 clocks. The completion flag becomes visible 16*H clock cycles after the clock edge that accepts the data write.
- R3: Each transfer produces exactly 16 SCK edges and shifts the byte out on `mosi` MSB first.
  - With phase 0, the first bit is on `mosi` before the first edge, `mosi` changes on trailing edges, and data is sampled on leading edges.
  - With phase 1, `mosi` changes on leading edges and data is sampled on trailing edges.
- R4: The eight bits sampled from `miso` are assembled MSB first. They are copied into the receive buffer on the last cycle of the transfer, and address 2 reads this buffer.
- R5: The completion flag sets when a transfer finishes. `irq` equals the flag AND interrupt enable AND NOT `irq_mask`.
- R6: The flag clears only through this sequence: a status read while the flag is set, followed by a data-address read or write. A data read without the prior status read leaves the flag set.
- R7: While the flag is set and no status read has armed the clear, a data write is ignored. No transfer starts, SCK stays idle and the receive buffer keeps its value. After the arming read, a data write both starts a transfer and clears the flag.
- R8: A status read made while the flag is clear does not arm the clear. A later data access after the flag sets leaves the flag set.
- R9: If `ss_n` is low while the enable and master bits are both set, then in the next cycle:
  - the enable and master bits read 0;
  - the mode fault bit reads 1;
  - any transfer is abandoned without setting the flag, and SCK returns to the polarity level.
- R10: Any write to the control address clears the mode fault bit.
- R11: A data write made while the block is not an enabled master with `ss_n` high starts no transfer.
- R12: While no transfer is running, `sck` follows the clock polarity bit, one cycle after that bit is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (drives side effects only) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from reg_addr |
| irq_mask | input | 1 | Global interrupt mask, high blocks irq |
| irq | output | 1 | Interrupt request |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | input | 1 | Select guard, low forces a mode fault in master mode |

## Verification
The hardest situation to reach is a data access that lands while the flag is pending but the clear has not been armed, together with its mirror case, a status read that was made too early to arm anything. The bench reaches both on purpose.
- It parks a finished transfer and then issues a data read and a data write without any status read.
- It reads status before starting a transfer and only then lets that transfer complete.
- In each case it observes the flag, the receive buffer and SCK by reading `reg_rdata` while `reg_rd` is held low, so the observation cannot arm the clear.

A second hard case is the mode fault in the middle of a byte. The bench drops `ss_n` partway through a slow transfer and checks that no completion follows afterwards.

// File: rtl/spi_pkg.sv
package spi_pkg;
  localparam int DATA_W   = 8;
  localparam int ADDR_W   = 2;
  localparam int RATE_W   = 2;
  localparam int HALF_W   = 5;
  localparam int CTRL_W   = 7;
  localparam int EDGE_W   = $clog2(2 * DATA_W);

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_DATA = 2'd2;

  typedef struct packed {
    logic              irq_en;
    logic [RATE_W-1:0] rate;
    logic              cpha;
    logic              cpol;
    logic              mstr;
    logic              en;
  } ctrl_t;

  // Half SCK period in system clocks for each rate code.
  function automatic logic [HALF_W-1:0] half_period(input logic [RATE_W-1:0] code);
    case (code)
      2'b00:   half_period = HALF_W'(1);
      2'b01:   half_period = HALF_W'(2);
      2'b10:   half_period = HALF_W'(8);
      default: half_period = HALF_W'(16);
    endcase
  endfunction
endpackage

// File: rtl/spi_baud_gen.sv
module spi_baud_gen #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             run,
  input  logic [CNT_W-1:0] half,
  output logic             tick
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             wrap;

  assign wrap = (cnt_q == half - CNT_W'(1));
  assign tick = run && wrap;

  always_comb begin
    cnt_d = cnt_q;
    if (!run)      cnt_d = '0;
    else if (wrap) cnt_d = '0;
    else           cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
  parameter int DW = 8,
  localparam int EW = $clog2(2 * DW)
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          start,
  input  logic [DW-1:0] tx_data,
  input  logic          cpol,
  input  logic          cpha,
  input  logic          abort,
  input  logic          tick,
  input  logic          miso,
  output logic          busy,
  output logic          sck,
  output logic          mosi,
  output logic          done,
  output logic [DW-1:0] rx_data
);
  logic          busy_q, busy_d;
  logic [EW-1:0] edge_q, edge_d;
  logic          sck_q, sck_d;
  logic          mosi_q, mosi_d;
  logic [DW-1:0] sh_q, sh_d;
  logic          last_edge, drive_edge;

  assign last_edge  = (edge_q == EW'(2 * DW - 1));
  // Phase 0 drives on odd (trailing) edges, phase 1 on even (leading) edges.
  assign drive_edge = cpha ? ~edge_q[0] : edge_q[0];

  always_comb begin
    busy_d = busy_q;
    edge_d = edge_q;
    sck_d  = sck_q;
    mosi_d = mosi_q;
    sh_d   = sh_q;
    if (abort) begin
      busy_d = 1'b0;
      sck_d  = cpol;
    end else if (start && !busy_q) begin
      busy_d = 1'b1;
      edge_d = '0;
      sck_d  = cpol;
      if (cpha) begin
        sh_d = tx_data;
      end else begin
        sh_d   = {tx_data[DW-2:0], 1'b0};
        mosi_d = tx_data[DW-1];
      end
    end else if (busy_q && tick) begin
      sck_d  = ~sck_q;
      edge_d = edge_q + EW'(1);
      if (last_edge) begin
        busy_d = 1'b0;
      end else if (drive_edge) begin
        mosi_d = sh_q[DW-1];
        sh_d   = {sh_q[DW-2:0], 1'b0};
      end else begin
        sh_d[0] = miso;
      end
    end else if (!busy_q) begin
      sck_d = cpol;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      edge_q <= '0;
      sck_q  <= 1'b0;
      mosi_q <= 1'b0;
      sh_q   <= '0;
    end else begin
      busy_q <= busy_d;
      edge_q <= edge_d;
      sck_q  <= sck_d;
      mosi_q <= mosi_d;
      sh_q   <= sh_d;
    end
  end

  assign busy    = busy_q;
  assign sck     = sck_q;
  assign mosi    = mosi_q;
  assign done    = busy_q && tick && last_edge && !abort;
  // With phase 1 the final edge is a sampling edge, so take miso directly.
  assign rx_data = cpha ? {sh_q[DW-1:1], miso} : sh_q;

  assert_sck_idle_R12: assert property (@(posedge clk) disable iff (!rst_ni)
    (!busy_q && $past(!busy_q) && $stable(cpol)) |-> (sck_q == cpol));

  assert_end_at_idle_R12: assert property (@(posedge clk) disable iff (!rst_ni)
    ($fell(busy_q) && !$past(abort)) |-> (sck_q == $past(cpol)));
endmodule

// File: rtl/spi_done_flag.sv
module spi_done_flag (
  input  logic clk,
  input  logic rst_ni,
  input  logic set,
  input  logic stat_rd,
  input  logic data_acc,
  output logic flag,
  output logic armed
);
  logic flag_q, flag_d;
  logic armed_q, armed_d;

  always_comb begin
    flag_d  = flag_q;
    armed_d = armed_q;
    if (stat_rd && flag_q) armed_d = 1'b1;
    if (data_acc && armed_q) begin
      flag_d  = 1'b0;
      armed_d = 1'b0;
    end
    if (set) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      flag_q  <= flag_d;
      armed_q <= armed_d;
    end
  end

  assign flag  = flag_q;
  assign armed = armed_q;

  assert_clear_sequence_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    $fell(flag_q) |-> $past(armed_q && data_acc));

  assert_arm_needs_flag_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(armed_q) |-> $past(flag_q && stat_rd));
endmodule

// File: rtl/spi_master_ctrl.sv
module spi_master_ctrl
  import spi_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic              irq_mask,
  output logic              irq,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  input  logic              ss_n
);
  // Reset: asynchronous assertion, synchronous release.
  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  ctrl_t          ctrl_q, ctrl_d;
  logic           fault_q, fault_d;
  logic [DW-1:0]  rxbuf_q, rxbuf_d;

  logic ctrl_wr, stat_rd, data_wr, data_rd, data_acc;
  logic fault_evt, active, wr_ok;
  logic busy, xfer_done, tick, flag, armed;
  logic [DW-1:0]     rx_data;
  logic [HALF_W-1:0] half;

  assign ctrl_wr   = reg_wr && (reg_addr == ADDR_CTRL);
  assign stat_rd   = reg_rd && (reg_addr == ADDR_STAT);
  assign data_wr   = reg_wr && (reg_addr == ADDR_DATA);
  assign data_rd   = reg_rd && (reg_addr == ADDR_DATA);
  assign data_acc  = data_wr || data_rd;

  assign fault_evt = ctrl_q.en && ctrl_q.mstr && !ss_n;
  assign active    = ctrl_q.en && ctrl_q.mstr && ss_n;
  assign wr_ok     = data_wr && (!flag || armed) && active && !busy;
  assign half      = half_period(ctrl_q.rate);

  always_comb begin
    ctrl_d  = ctrl_q;
    fault_d = fault_q;
    if (ctrl_wr) begin
      ctrl_d  = ctrl_t'(reg_wdata[CTRL_W-1:0]);
      fault_d = 1'b0;
    end
    if (fault_evt) begin
      ctrl_d.en   = 1'b0;
      ctrl_d.mstr = 1'b0;
      fault_d     = 1'b1;
    end
  end

  always_comb begin
    rxbuf_d = rxbuf_q;
    if (xfer_done) rxbuf_d = rx_data;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      fault_q <= 1'b0;
      rxbuf_q <= '0;
    end else begin
      ctrl_q  <= ctrl_d;
      fault_q <= fault_d;
      rxbuf_q <= rxbuf_d;
    end
  end

  spi_baud_gen #(.CNT_W(HALF_W)) u_baud (
    .clk    (clk),
    .rst_ni (rst_ni),
    .run    (busy),
    .half   (half),
    .tick   (tick)
  );

  spi_shift_engine #(.DW(DW)) u_shift (
    .clk     (clk),
    .rst_ni  (rst_ni),
    .start   (wr_ok),
    .tx_data (reg_wdata),
    .cpol    (ctrl_q.cpol),
    .cpha    (ctrl_q.cpha),
    .abort   (fault_evt),
    .tick    (tick),
    .miso    (miso),
    .busy    (busy),
    .sck     (sck),
    .mosi    (mosi),
    .done    (xfer_done),
    .rx_data (rx_data)
  );

  spi_done_flag u_flag (
    .clk      (clk),
    .rst_ni   (rst_ni),
    .set      (xfer_done),
    .stat_rd  (stat_rd),
    .data_acc (data_acc),
    .flag     (flag),
    .armed    (armed)
  );

  always_comb begin
    case (reg_addr)
      ADDR_CTRL: reg_rdata = DW'({1'b0, ctrl_q});
      ADDR_STAT: reg_rdata = {flag, fault_q, {(DW-2){1'b0}}};
      ADDR_DATA: reg_rdata = rxbuf_q;
      default:   reg_rdata = '0;
    endcase
  end

  assign irq = flag && ctrl_q.irq_en && !irq_mask;

  assert_done_sets_flag_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    xfer_done |=> flag);

  assert_blocked_write_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    (data_wr && flag && !armed) |=> (!busy && $stable(rxbuf_q)));

  assert_fault_drop_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    fault_evt |=> (!ctrl_q.en && !ctrl_q.mstr && fault_q && !busy));

  assert_fault_clear_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    (ctrl_wr && !fault_evt) |=> !fault_q);
endmodule

// File: tb/spi_master_ctrl_tb.sv
`timescale 1ns/1ps
module spi_master_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] reg_addr;
  logic       reg_wr, reg_rd;
  logic [7:0] reg_wdata, reg_rdata;
  logic       irq_mask, irq, sck, mosi, miso, ss_n;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  spi_master_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_mask(irq_mask), .irq(irq),
    .sck(sck), .mosi(mosi), .miso(miso), .ss_n(ss_n)
  );

  // Each entry is {rate[19:18], cpol[17], cpha[16], tx[15:8], slave_tx[7:0]}.
  localparam logic [19:0] VEC [8] = '{
    {2'd0, 1'b0, 1'b0, 8'hA5, 8'h3C},
    {2'd1, 1'b0, 1'b1, 8'h96, 8'hC3},
    {2'd0, 1'b1, 1'b0, 8'hF0, 8'h0F},
    {2'd2, 1'b1, 1'b1, 8'h01, 8'h80},
    {2'd3, 1'b0, 1'b0, 8'h7E, 8'h81},
    {2'd1, 1'b1, 1'b0, 8'hFF, 8'h00},
    {2'd0, 1'b0, 1'b1, 8'h00, 8'hFF},
    {2'd2, 1'b0, 1'b0, 8'h5A, 8'hA5}
  };

  function automatic logic [7:0] cfg(input logic [1:0] rate, input logic cpol,
                                     input logic cpha, input logic ie);
    return {1'b0, ie, rate, cpha, cpol, 1'b1, 1'b1};
  endfunction

  function automatic int half_of(input logic [1:0] rate);
    case (rate)
      2'd0: return 1;
      2'd1: return 2;
      2'd2: return 8;
      default: return 16;
    endcase
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  // Look at a register without a read strobe: no side effects.
  task automatic peek(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic run_xfer(input logic cpha, input logic [7:0] tx, input logic [7:0] stx,
                          output logic [7:0] got, output int cyc);
    got = 8'h00;
    cyc = 0;
    miso = cpha ? 1'b0 : stx[7];
    reg_write(2'd2, tx);
    reg_addr = 2'd1;
    fork
      begin
        for (int i = 0; i < 16; i++) begin
          @(sck);
          if (!cpha) begin
            if (i % 2 == 0) got = {got[6:0], mosi};
            else if (i < 15) miso = stx[6 - i/2];
          end else begin
            if (i % 2 == 0) miso = stx[7 - i/2];
            else got = {got[6:0], mosi};
          end
        end
      end
      begin
        for (int n = 1; n <= 1000; n++) begin
          @(negedge clk);
          #1;
          if (reg_rdata[7]) begin
            cyc = n;
            break;
          end
        end
      end
    join
  endtask

  task automatic clear_flag();
    logic [7:0] d;
    reg_read(2'd1, d);
    reg_read(2'd2, d);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] d, got;
    int cyc;
    rst_n = 1'b0; reg_addr = 2'd0; reg_wr = 1'b0; reg_rd = 1'b0; reg_wdata = 8'h00;
    irq_mask = 1'b0; miso = 1'b0; ss_n = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    peek(2'd0, d); chk("R1 ctrl", d, 8'h00);
    peek(2'd1, d); chk("R1 status", d, 8'h00);
    peek(2'd2, d); chk("R1 data", d, 8'h00);
    chk("R1 sck", {7'b0, sck}, 8'h00);
    chk("R1 irq", {7'b0, irq}, 8'h00);

    // R12 idle level follows polarity
    reg_write(2'd0, cfg(2'd0, 1'b1, 1'b0, 1'b0));
    @(negedge clk);
    chk("R12 idle high", {7'b0, sck}, 8'h01);
    reg_write(2'd0, cfg(2'd0, 1'b0, 1'b0, 1'b0));
    @(negedge clk);
    chk("R12 idle low", {7'b0, sck}, 8'h00);

    // Vector table: rates, modes and patterns
    foreach (VEC[k]) begin
      reg_write(2'd0, cfg(VEC[k][19:18], VEC[k][17], VEC[k][16], 1'b0));
      repeat (2) @(negedge clk);
      run_xfer(VEC[k][16], VEC[k][15:8], VEC[k][7:0], got, cyc);
      chk("R3 mosi byte", got, VEC[k][15:8]);
      peek(2'd2, d); chk("R4 rx buffer", d, VEC[k][7:0]);
      chk("R2 flag latency", 8'(cyc), 8'(16 * half_of(VEC[k][19:18])));
      clear_flag();
      peek(2'd1, d); chk("R6 flag cleared", d & 8'h80, 8'h00);
    end

    // R5 interrupt gating
    reg_write(2'd0, cfg(2'd1, 1'b0, 1'b0, 1'b1));
    repeat (2) @(negedge clk);
    run_xfer(1'b0, 8'hC3, 8'h5A, got, cyc);
    peek(2'd1, d); chk("R5 flag set", d & 8'h80, 8'h80);
    chk("R5 irq high", {7'b0, irq}, 8'h01);
    irq_mask = 1'b1; #1;
    chk("R5 irq masked", {7'b0, irq}, 8'h00);
    irq_mask = 1'b0;
    reg_write(2'd0, cfg(2'd1, 1'b0, 1'b0, 1'b0));
    chk("R5 irq disabled", {7'b0, irq}, 8'h00);
    reg_write(2'd0, cfg(2'd1, 1'b0, 1'b0, 1'b1));

    // R6 data read without arming does not clear
    reg_read(2'd2, d);
    peek(2'd1, d); chk("R6 no clear without status read", d & 8'h80, 8'h80);

    // R7 blocked write while pending
    reg_write(2'd2, 8'h11);
    repeat (50) @(negedge clk);
    peek(2'd1, d); chk("R7 flag still set", d & 8'h80, 8'h80);
    peek(2'd2, d); chk("R7 buffer kept", d, 8'h5A);
    chk("R7 sck idle", {7'b0, sck}, 8'h00);
    reg_read(2'd1, d);
    run_xfer(1'b0, 8'h11, 8'hE7, got, cyc);
    chk("R7 write after arming sends", got, 8'h11);
    peek(2'd2, d); chk("R7 new byte received", d, 8'hE7);
    clear_flag();

    // R8 early status read does not arm
    reg_read(2'd1, d);
    run_xfer(1'b0, 8'h3C, 8'h42, got, cyc);
    reg_read(2'd2, d);
    peek(2'd1, d); chk("R8 flag survives", d & 8'h80, 8'h80);
    clear_flag();
    peek(2'd1, d); chk("R6 later clear", d & 8'h80, 8'h00);

    // R9 mode fault mid-transfer
    reg_write(2'd0, cfg(2'd3, 1'b1, 1'b0, 1'b0));
    repeat (2) @(negedge clk);
    reg_write(2'd2, 8'hAA);
    repeat (40) @(negedge clk);
    ss_n = 1'b0;
    repeat (2) @(negedge clk);
    peek(2'd0, d); chk("R9 en/master dropped", d & 8'h03, 8'h00);
    peek(2'd1, d); chk("R9 fault set", d & 8'h40, 8'h40);
    chk("R9 sck at polarity", {7'b0, sck}, 8'h01);
    ss_n = 1'b1;
    repeat (600) @(negedge clk);
    peek(2'd1, d); chk("R9 no completion", d & 8'h80, 8'h00);

    // R10 control write clears fault
    reg_write(2'd0, cfg(2'd0, 1'b0, 1'b0, 1'b0));
    peek(2'd1, d); chk("R10 fault cleared", d & 8'h40, 8'h00);

    // R11 not enabled: write ignored
    reg_write(2'd0, 8'h02);
    reg_write(2'd2, 8'h33);
    repeat (100) @(negedge clk);
    peek(2'd1, d); chk("R11 no flag", d & 8'h80, 8'h00);
    chk("R11 sck idle", {7'b0, sck}, 8'h00);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule